// File: doc/BRIEF.md
# Interleaved Dual-Channel Sample Demultiplexer

This block takes one shared 12-bit sample bus and splits it into two output channels, A and B. Words for the two channels arrive interleaved on the bus at twice the per-channel rate. A rising edge on the write strobe captures the bus word into one of two input registers, and the select line picks which one. A separate conversion clock is divided by two inside the block. On each rising edge of the halved clock, both input registers move together into a pair of output holding registers, so the two channels present new values in the same cycle.

The write strobe and the conversion clock are treated as level inputs that are synchronous to a faster system clock `clk`. The block samples them on every `clk` edge and detects their rising edges, so all of its logic runs on one clock. The conversion-halt input gates the conversion path: while it is high, no conversion edge is counted and the outputs hold. A sticky guard flag reports a select change made while the strobe or the conversion clock was high.

There are two small state machines. The divider (`div2_fsm`) has the states DIV_HALT (parked, after reset or while halted), DIV_HIGH (halved clock high) and DIV_LOW (halved clock low). Its transitions are:
- *park*: any state goes to DIV_HALT while halted.
- *fall*: DIV_HALT or DIV_HIGH goes to DIV_LOW on a conversion edge.
- *launch*: DIV_LOW goes to DIV_HIGH on a conversion edge, and this transition drives the transfer.

The guard (`sel_guard`) has the states GUARD_CLEAN and GUARD_TRIPPED. Its only transition is *trip*, from GUARD_CLEAN to GUARD_TRIPPED on a select violation. Only the system reset leaves GUARD_TRIPPED.

Top module: `twin_lane_demux`

## Requirements
- R1: While `rst_n` is low, and after it is released, `out_a` and `out_b` read mid-scale 0x800 and `sel_fault` reads 0. The input registers reset to zero, so a transfer made before any write drives both outputs to 0x000.
- R2: A `clk` sample where `wr_stb` is 1 and was 0 at the previous sample captures `din` into the channel A input register if `lane_sel` is 1 at that sample, and into the channel B input register if `lane_sel` is 0.
- R3: A `wr_stb` that stays high over several samples captures only once, at its first high sample. Later `din` values seen while it stays high are not captured.
- R4: With `conv_halt` low, a transfer happens on every second rising edge of `conv_clk`. After system reset, or after `conv_halt` falls, the first edge does not transfer and the second one does.
- R5: A transfer copies both input registers to `out_a` and `out_b` together, visible after the `clk` edge that samples the conversion edge. The outputs change at no other time.
- R6: While `conv_halt` is high, `conv_clk` edges are ignored and the outputs hold, but strobe writes are still captured. `conv_halt` returns the divider to its post-reset phase.
- R7: When a write and a transfer fall on the same `clk` sample, the outputs receive the input register contents from before that write. The new word appears at the following transfer.
- R8: `sel_fault` is set when `lane_sel` differs from its previous sample while `wr_stb` or `conv_clk` is high at either of the two samples. Once set, it stays set until `rst_n` goes low.
- R9: A `lane_sel` change made while `wr_stb` and `conv_clk` are low at both samples leaves `sel_fault` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all other inputs |
| rst_n | input | 1 | Asynchronous active-low system reset |
| conv_halt | input | 1 | High gates off the conversion path and parks the divider |
| wr_stb | input | 1 | Write strobe level; its rising edge captures `din` |
| conv_clk | input | 1 | Conversion clock level; divided by two internally |
| lane_sel | input | 1 | Steers a captured word: 1 to channel A, 0 to channel B |
| din | input | 12 | Shared interleaved sample bus |
| out_a | output | 12 | Channel A output holding register |
| out_b | output | 12 | Channel B output holding register |
| sel_fault | output | 1 | Sticky flag for a select change made at a forbidden time |

## Verification
A strobe write and a divided-clock transfer can land on the same `clk` sample. The bench provokes this by raising `wr_stb` and `conv_clk` together in the launch phase. It then expects the outputs to carry the older input register contents, and expects the freshly written word only after the next transfer. A select change can also coincide with a strobe edge. In that case the word must still be steered by the new select level, and the guard flag must trip in the same cycle.

// File: rtl/twin_lane_pkg.sv
package twin_lane_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        DIV_HALT = 2'd0,
        DIV_HIGH = 2'd1,
        DIV_LOW  = 2'd2
    } div_state_e;

    typedef enum logic {
        GUARD_CLEAN   = 1'b0,
        GUARD_TRIPPED = 1'b1
    } guard_state_e;

endpackage

// File: rtl/edge_tap.sv
module edge_tap #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    for (genvar g = 0; g < N; g++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev[g] <= 1'b0;
            else        prev[g] <= lvl[g];
        end
    end
endmodule

// File: rtl/div2_fsm.sv
module div2_fsm
    import twin_lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic tick,
    output logic xfer
);
    div_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIV_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = DIV_HALT;                       // park
        end else if (tick) begin
            unique case (state_q)
                DIV_HALT: state_d = DIV_LOW;          // fall
                DIV_HIGH: state_d = DIV_LOW;          // fall
                DIV_LOW:  state_d = DIV_HIGH;         // launch
                default:  state_d = DIV_HALT;
            endcase
        end
    end

    always_comb begin
        xfer = 1'b0;
        unique case (state_q)
            DIV_LOW:  xfer = tick && !halt;
            DIV_HALT: xfer = 1'b0;
            DIV_HIGH: xfer = 1'b0;
            default:  xfer = 1'b0;
        endcase
    end
endmodule

// File: rtl/sel_guard.sv
module sel_guard
    import twin_lane_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_now,
    input  logic sel_prev,
    input  logic busy,
    output logic fault
);
    guard_state_e state_q, state_d;
    logic         violation;

    assign violation = (sel_now != sel_prev) && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GUARD_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_CLEAN:   if (violation) state_d = GUARD_TRIPPED;  // trip
            GUARD_TRIPPED: state_d = GUARD_TRIPPED;
            default:       state_d = GUARD_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            GUARD_TRIPPED: fault = 1'b1;
            GUARD_CLEAN:   fault = 1'b0;
            default:       fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_bank.sv
module lane_bank
    import twin_lane_pkg::*;
#(
    parameter int   W           = 12,
    parameter logic SEL_A_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         sel,
    input  logic         cap,
    input  logic         xfer,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b
);
    localparam logic [W-1:0] MID = W'(1) << (W - 1);

    logic [LANES-1:0][W-1:0] in_q;
    logic [LANES-1:0][W-1:0] hold_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic MATCH = (g == 0) ? SEL_A_LEVEL : !SEL_A_LEVEL;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     in_q[g] <= '0;
            else if (cap && (sel == MATCH)) in_q[g] <= din;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hold_q[g] <= MID;
            else if (xfer) hold_q[g] <= in_q[g];
        end
    end

    assign out_a = hold_q[0];
    assign out_b = hold_q[1];
endmodule

// File: rtl/twin_lane_demux.sv
module twin_lane_demux
    import twin_lane_pkg::*;
#(
    parameter int   W           = 12,
    parameter logic SEL_A_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_halt,
    input  logic         wr_stb,
    input  logic         conv_clk,
    input  logic         lane_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] out_a,
    output logic [W-1:0] out_b,
    output logic         sel_fault
);
    localparam int NTAP = 3;
    localparam int T_WR   = 0;
    localparam int T_CONV = 1;
    localparam int T_SEL  = 2;

    logic [NTAP-1:0] lvl, prev;
    logic            wr_rise, conv_rise, xfer, busy;

    assign lvl = {lane_sel, conv_clk, wr_stb};

    edge_tap #(.N(NTAP)) u_tap (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .prev (prev)
    );

    assign wr_rise   = wr_stb   && !prev[T_WR];
    assign conv_rise = conv_clk && !prev[T_CONV];
    assign busy      = wr_stb || conv_clk || prev[T_WR] || prev[T_CONV];

    div2_fsm u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .halt (conv_halt),
        .tick (conv_rise),
        .xfer (xfer)
    );

    sel_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_now (lane_sel),
        .sel_prev(prev[T_SEL]),
        .busy    (busy),
        .fault   (sel_fault)
    );

    lane_bank #(.W(W), .SEL_A_LEVEL(SEL_A_LEVEL)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .sel  (lane_sel),
        .cap  (wr_rise),
        .xfer (xfer),
        .out_a(out_a),
        .out_b(out_b)
    );
endmodule

// File: rtl/twin_lane_demux_chk.sv
module twin_lane_demux_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_halt,
    input logic         wr_stb,
    input logic         conv_clk,
    input logic         lane_sel,
    input logic [W-1:0] out_a,
    input logic [W-1:0] out_b,
    input logic         sel_fault,
    input logic         xfer
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_halt |=> ($stable(out_a) && $stable(out_b)));

    // R6
    halt_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_halt |-> !xfer);

    // R4
    xfer_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer);

    // R5
    out_change_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (!$stable(out_a) || !$stable(out_b)) |-> $past(xfer));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fault |=> sel_fault);

    // R8
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ((lane_sel != $past(lane_sel)) && (wr_stb || conv_clk)) |=> sel_fault);
endmodule

bind twin_lane_demux twin_lane_demux_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_halt(conv_halt),
    .wr_stb   (wr_stb),
    .conv_clk (conv_clk),
    .lane_sel (lane_sel),
    .out_a    (out_a),
    .out_b    (out_b),
    .sel_fault(sel_fault),
    .xfer     (xfer)
);

// File: tb/tb_twin_lane_demux.sv
`timescale 1ns/1ps
module tb_twin_lane_demux;
    localparam int W = 12;
    localparam logic [W-1:0] MID = 12'h800;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_halt = 1'b0;
    logic         wr_stb = 1'b0;
    logic         conv_clk = 1'b0;
    logic         lane_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] out_a, out_b;
    logic         sel_fault;

    twin_lane_demux #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .conv_halt(conv_halt), .wr_stb(wr_stb),
        .conv_clk(conv_clk), .lane_sel(lane_sel), .din(din),
        .out_a(out_a), .out_b(out_b), .sel_fault(sel_fault)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic         xf;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         f;
        int           due;
        string        tag;
    } item_t;

    item_t        sb[$];
    int           cyc = 0;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    // reference model state
    logic [W-1:0] ea, eb, last_a, last_b;
    logic         ef, ph, pw, pc, ps;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic model_reset();
        ea = '0; eb = '0; ef = 1'b0; ph = 1'b0;
        pw = 1'b0; pc = 1'b0; ps = 1'b0;
        last_a = MID; last_b = MID;
    endtask

    // driver: one system-clock sample per call
    task automatic step(input logic w, input logic c, input logic s,
                        input logic h, input logic [W-1:0] d, input string tag);
        item_t it;
        logic  wrise, crise, x;
        @(negedge clk);
        wr_stb = w; conv_clk = c; lane_sel = s; conv_halt = h; din = d;
        wrise = w && !pw;
        crise = c && !pc;
        x     = crise && !h && ph;
        it.xf = x; it.a = ea; it.b = eb;
        if (h)          ph = 1'b0;
        else if (crise) ph = !ph;
        if (wrise) begin
            if (s) ea = d;
            else   eb = d;
        end
        if ((s != ps) && (w || c || pw || pc)) ef = 1'b1;
        it.f = ef; it.due = cyc + 1; it.tag = tag;
        sb.push_back(it);
        pw = w; pc = c; ps = s;
    endtask

    // monitor: pops and compares after each sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                logic [W-1:0] xa, xb;
                it = sb.pop_front();
                xa = it.xf ? it.a : last_a;
                xb = it.xf ? it.b : last_b;
                checks++;
                if (out_a !== xa || out_b !== xb || sel_fault !== it.f) begin
                    errors++;
                    $display("FAIL %s: out_a=%h out_b=%h fault=%b expected %h %h %b",
                             it.tag, out_a, out_b, sel_fault, xa, xb, it.f);
                end
                last_a = xa; last_b = xb;
            end
        end
    end

    task automatic check_reset(input string tag);
        checks++;
        if (out_a !== MID || out_b !== MID || sel_fault !== 1'b0) begin
            errors++;
            $display("FAIL %s: out_a=%h out_b=%h fault=%b expected %h %h 0",
                     tag, out_a, out_b, sel_fault, MID, MID);
        end
    endtask

    task automatic sys_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        wr_stb = 0; conv_clk = 0; lane_sel = 0; conv_halt = 0; din = '0;
        model_reset();
        @(negedge clk);
        check_reset("R1 reset values");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic conv_pulse(input string tag);
        step(1'b0, 1'b1, ps, 1'b0, din, tag);
        step(1'b0, 1'b0, ps, 1'b0, din, tag);
    endtask

    task automatic write_word(input logic s, input logic [W-1:0] d, input string tag);
        step(1'b0, 1'b0, s, 1'b0, din, tag);
        step(1'b1, 1'b0, s, 1'b0, d, tag);
        step(1'b0, 1'b0, s, 1'b0, d, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        check_reset("R1 reset values");
        rst_n = 1'b1;

        // R1 / R4: first edge after reset parks, second transfers zeros
        conv_pulse("R4 first edge no transfer");
        conv_pulse("R1 transfer of reset input regs");

        // R2 / R9: steering, quiet select changes
        write_word(1'b1, 12'h123, "R2 write to A");
        write_word(1'b0, 12'h456, "R9 quiet select change");
        conv_pulse("R4 edge without transfer");
        conv_pulse("R5 joint transfer");

        // R3: held strobe captures once
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h000, "R3 setup");
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h0AA, "R3 first high");
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h0BB, "R3 held high");
        step(1'b1, 1'b0, 1'b1, 1'b0, 12'h0CC, "R3 held high");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h0CC, "R3 release");
        conv_pulse("R4 edge without transfer");
        conv_pulse("R3 captured once");

        // R7: write and transfer on the same sample
        write_word(1'b0, 12'h777, "R2 write to B");
        conv_pulse("R4 edge without transfer");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h000, "R7 setup");
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'hABC, "R7 same-cycle write and transfer");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'hABC, "R7 release");
        conv_pulse("R4 edge without transfer");
        conv_pulse("R7 new word at next transfer");

        // R6: halt gates conversion, writes still land
        step(1'b0, 1'b0, 1'b1, 1'b1, 12'h000, "R6 halt on");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R6 edge ignored");
            step(1'b0, 1'b0, 1'b1, 1'b1, 12'h000, "R6 edge ignored");
        end
        step(1'b1, 1'b0, 1'b1, 1'b1, 12'h3C3, "R6 write during halt");
        step(1'b0, 1'b0, 1'b1, 1'b1, 12'h3C3, "R6 write during halt");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h3C3, "R6 halt off");
        conv_pulse("R6 first edge after halt no transfer");
        conv_pulse("R6 second edge transfers");
        conv_pulse("R4 odd edge");
        conv_pulse("R4 even edge");

        // R8: select change while strobe high, with capture steered by new level
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h000, "R8 setup");
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h5A5, "R8 select change at strobe edge");
        step(1'b0, 1'b0, 1'b0, 1'b0, 12'h5A5, "R8 sticky");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h5A5, "R8 sticky");
        conv_pulse("R8 sticky");
        conv_pulse("R2 steered by new select");

        // R8 via conversion clock high, after clearing with system reset
        repeat (2) @(negedge clk);
        sys_reset();
        step(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, "R8 conv high");
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000, "R8 change while conv high");
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h000, "R8 sticky");
        repeat (2) @(negedge clk);
        sys_reset();
        write_word(1'b1, 12'hFFF, "R9 flag clear after reset");
        conv_pulse("R4 edge without transfer");
        conv_pulse("R5 transfer after reset");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule